// File: doc/BRIEF.md
# Floppy Data-Rate Control Register

This block is the write-only control register that sits on the host side of a floppy disk controller. It holds the data-rate code, the write-precompensation code and an oscillator shut-off bit, and presents them to the rest of the controller. Writing a 1 to its top bit produces a one-cycle software reset pulse and returns the fields to their defaults. The bit then reads as cleared without any further host write. The block has no read path, so host reads at its address cannot return the stored fields.

A second bit puts the controller into power-down. In power-down the internal clock enable and the oscillator enable drop, and every drive select and motor enable output is forced inactive. Power-down stays active until a reset arrives. The reset can be the software reset bit, a reset request from the controller's other reset sources, or the global reset. Writing the power-down bit back to 0 does not end it.

The logical drive select and motor enable lines pass through a remap stage before they reach the drive outputs. Two strap inputs set the remap, so the controller can boot from a drive other than physical drive 0.

Top module: `fdc_rate_ctl`

## Requirements
- R1: After the synchronous reset `rst`, the outputs read as follows: `rate_o`=0, `pcomp_o`=0, `srst_pulse_o`=0, `pd_o`=0, `clk_en_o`=1, `osc_en_o`=1, `out_valid_n_o`=0, and all drive select and motor outputs are 0.
- R2: A write with `wr_en`=1, `addr`=REG_ADDR (default 4) and `wdata[7]`=0 loads `wdata[1:0]` into `rate_o` and `wdata[4:2]` into `pcomp_o`. Both are visible in the cycle after the write edge.
- R3: A write to any other address, or a cycle with `wr_en`=0, leaves the rate, precompensation, oscillator and power-down state unchanged.
- R4: A register write with `wdata[7]`=1 raises `srst_pulse_o` for exactly one cycle after the write edge. That write clears the rate and precompensation fields and the oscillator-off bit to 0, ends power-down, and has all its other bits ignored.
- R5: A register write with `wdata[6]`=1 and `wdata[7]`=0 enters power-down from the next cycle. In power-down, `pd_o`=1, `out_valid_n_o`=1, `clk_en_o`=0 and `osc_en_o`=0, and every drive select and motor output is 0.
- R6: While in power-down, writes with `wdata[7]`=0 (including `wdata[6]`=0) do not leave power-down, but they still update the rate and precompensation fields.
- R7: A one-cycle `hw_rst_req` clears the fields and ends power-down without raising `srst_pulse_o`. Drive outputs then follow the remapped inputs again.
- R8: `wdata[5]`=1 on a register write drops `osc_en_o` while `clk_en_o` stays 1 and power-down is not entered. Writing it back to 0 restores `osc_en_o`.
- R9: With `boot_strap`=00, or with the reserved value 11, physical output n carries logical line n.
- R10: With `boot_strap`=01, physical output 0 carries logical drive 1, output 1 carries logical drive 0, and output 2 carries drive 2.
- R11: With `boot_strap`=10, physical output 0 carries logical drive 2, output 2 carries logical drive 0, and output 1 carries drive 1.
- R12: The motor enable lines are remapped exactly as the select lines are. Outside power-down, every drive output is registered: it follows its inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| hw_rst_req | input | 1 | Reset request from the controller's other reset sources |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Host register address |
| wdata | input | 8 | Host write data |
| boot_strap | input | 2 | Boot drive remap straps |
| sel_in | input | NUM_DRV | Logical drive select lines, active high |
| mot_in | input | NUM_DRV | Logical motor enable lines, active high |
| sel_o | output | NUM_DRV | Physical drive select outputs |
| mot_o | output | NUM_DRV | Physical motor enable outputs |
| rate_o | output | 2 | Data-rate code |
| pcomp_o | output | 3 | Precompensation code |
| srst_pulse_o | output | 1 | One-cycle software reset pulse |
| pd_o | output | 1 | Power-down active |
| clk_en_o | output | 1 | Internal clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| out_valid_n_o | output | 1 | Low while the drive outputs are live |

## Verification
The bench sweeps every strap code against every select and motor pattern. A remap that swapped the wrong pair, or that treated the reserved code as a swap, would produce a mismatched drive output.

It tries to leave power-down with a plain write of 0. It then checks that the drives stay dark, which would fail if the power-down bit were stored as an ordinary field.

It writes a value with every bit set. This shows that the software reset wins over the other bits, and that the reset pulse lasts exactly one cycle; a pulse that stuck or repeated would show up at once.

A write to a neighbouring address and a strobe-less cycle confirm that no stray decode changes the stored state.

// File: rtl/fdc_rate_pkg.sv
`timescale 1ns/1ps
package fdc_rate_pkg;
  localparam int DATA_W     = 8;
  localparam int RATE_W     = 2;
  localparam int PCOMP_W    = 3;
  localparam int BIT_SRST   = 7;
  localparam int BIT_PDWN   = 6;
  localparam int BIT_OSCOFF = 5;
  localparam int PCOMP_LSB  = 2;
  localparam int RATE_LSB   = 0;

  typedef enum logic [1:0] {
    BOOT_DIRECT  = 2'b00,
    BOOT_SWAP_01 = 2'b01,
    BOOT_SWAP_02 = 2'b10,
    BOOT_RSVD    = 2'b11
  } boot_map_e;

  typedef struct packed {
    logic               osc_off;
    logic [PCOMP_W-1:0] pcomp;
    logic [RATE_W-1:0]  rate;
  } rate_fields_t;

  localparam rate_fields_t FIELDS_RST = '0;
endpackage

// File: rtl/fdc_rate_regs.sv
`timescale 1ns/1ps
module fdc_rate_regs
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_rst_req,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output rate_fields_t      fields_q,
  output rate_fields_t      fields_d,
  output logic              srst_pulse_q,
  output logic              pd_set,
  output logic              clr_now
);
  logic srst_wr;

  assign srst_wr = wr_hit & wdata[BIT_SRST];
  assign clr_now = hw_rst_req | srst_wr;
  assign pd_set  = wr_hit & wdata[BIT_PDWN] & ~wdata[BIT_SRST];

  always_comb begin
    fields_d = fields_q;
    if (clr_now) begin
      fields_d = FIELDS_RST;
    end else if (wr_hit) begin
      fields_d.osc_off = wdata[BIT_OSCOFF];
      fields_d.pcomp   = wdata[PCOMP_LSB +: PCOMP_W];
      fields_d.rate    = wdata[RATE_LSB +: RATE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q     <= FIELDS_RST;
      srst_pulse_q <= 1'b0;
    end else begin
      fields_q     <= fields_d;
      srst_pulse_q <= srst_wr & ~srst_pulse_q;
    end
  end

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    srst_pulse_q |=> !srst_pulse_q); // R4
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (fields_q == FIELDS_RST)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !hw_rst_req) |=> $stable(fields_q)); // R3
endmodule

// File: rtl/fdc_pwr_ctl.sv
`timescale 1ns/1ps
module fdc_pwr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic clr_now,
  input  logic pd_set,
  input  logic osc_off_d,
  output logic pd_d,
  output logic pd_q,
  output logic clk_en_q,
  output logic osc_en_q,
  output logic valid_n_q
);
  always_comb begin
    if (clr_now)     pd_d = 1'b0;
    else if (pd_set) pd_d = 1'b1;
    else             pd_d = pd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q      <= 1'b0;
      clk_en_q  <= 1'b1;
      osc_en_q  <= 1'b1;
      valid_n_q <= 1'b0;
    end else begin
      pd_q      <= pd_d;
      clk_en_q  <= ~pd_d;
      osc_en_q  <= ~(pd_d | osc_off_d);
      valid_n_q <= pd_d;
    end
  end

  AST_PD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pd_q && !clr_now) |=> pd_q); // R6
  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    pd_q |-> (!clk_en_q && !osc_en_q && valid_n_q)); // R5
  AST_CLR_EXITS: assert property (@(posedge clk) disable iff (rst)
    clr_now |=> (!pd_q && clk_en_q)); // R7
endmodule

// File: rtl/fdc_boot_remap.sv
`timescale 1ns/1ps
module fdc_boot_remap
  import fdc_rate_pkg::*;
#(
  parameter int NUM_DRV = 3
) (
  input  boot_map_e          map,
  input  logic [NUM_DRV-1:0] sel_i,
  input  logic [NUM_DRV-1:0] mot_i,
  output logic [NUM_DRV-1:0] sel_m,
  output logic [NUM_DRV-1:0] mot_m
);
  localparam int IDX_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;

  for (genvar p = 0; p < NUM_DRV; p++) begin : g_drv
    localparam logic [IDX_W-1:0] SRC_SELF = IDX_W'(p);
    localparam logic [IDX_W-1:0] SRC_S01  =
      (p == 0) ? IDX_W'(1) : ((p == 1) ? IDX_W'(0) : IDX_W'(p));
    localparam logic [IDX_W-1:0] SRC_S02  =
      (p == 0) ? IDX_W'(2) : ((p == 2) ? IDX_W'(0) : IDX_W'(p));
    logic [IDX_W-1:0] src;

    always_comb begin
      case (map)
        BOOT_SWAP_01: src = SRC_S01;
        BOOT_SWAP_02: src = SRC_S02;
        default:      src = SRC_SELF;
      endcase
    end

    assign sel_m[p] = sel_i[src];
    assign mot_m[p] = mot_i[src];
  end
endmodule

// File: rtl/fdc_rate_ctl.sv
`timescale 1ns/1ps
module fdc_rate_ctl
  import fdc_rate_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 4,
  parameter int NUM_DRV  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hw_rst_req,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [1:0]           boot_strap,
  input  logic [NUM_DRV-1:0]   sel_in,
  input  logic [NUM_DRV-1:0]   mot_in,
  output logic [NUM_DRV-1:0]   sel_o,
  output logic [NUM_DRV-1:0]   mot_o,
  output logic [RATE_W-1:0]    rate_o,
  output logic [PCOMP_W-1:0]   pcomp_o,
  output logic                 srst_pulse_o,
  output logic                 pd_o,
  output logic                 clk_en_o,
  output logic                 osc_en_o,
  output logic                 out_valid_n_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic         wr_hit;
  rate_fields_t fields_q;
  rate_fields_t fields_d;
  logic         pd_set;
  logic         clr_now;
  logic         pd_d;
  logic [NUM_DRV-1:0] sel_m;
  logic [NUM_DRV-1:0] mot_m;

  assign wr_hit = wr_en && (addr == HIT_ADDR);

  fdc_rate_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .hw_rst_req   (hw_rst_req),
    .wr_hit       (wr_hit),
    .wdata        (wdata),
    .fields_q     (fields_q),
    .fields_d     (fields_d),
    .srst_pulse_q (srst_pulse_o),
    .pd_set       (pd_set),
    .clr_now      (clr_now)
  );

  fdc_pwr_ctl u_pwr (
    .clk       (clk),
    .rst       (rst),
    .clr_now   (clr_now),
    .pd_set    (pd_set),
    .osc_off_d (fields_d.osc_off),
    .pd_d      (pd_d),
    .pd_q      (pd_o),
    .clk_en_q  (clk_en_o),
    .osc_en_q  (osc_en_o),
    .valid_n_q (out_valid_n_o)
  );

  fdc_boot_remap #(.NUM_DRV(NUM_DRV)) u_remap (
    .map   (boot_map_e'(boot_strap)),
    .sel_i (sel_in),
    .mot_i (mot_in),
    .sel_m (sel_m),
    .mot_m (mot_m)
  );

  always_ff @(posedge clk) begin
    if (rst || pd_d) begin
      sel_o <= '0;
      mot_o <= '0;
    end else begin
      sel_o <= sel_m;
      mot_o <= mot_m;
    end
  end

  assign rate_o  = fields_q.rate;
  assign pcomp_o = fields_q.pcomp;

  AST_PD_DRIVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    pd_o |-> (sel_o == '0 && mot_o == '0)); // R5
  AST_RSVD_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (boot_strap == 2'b11 && !pd_d) |=> (sel_o == $past(sel_in) && mot_o == $past(mot_in))); // R9
  AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (rst)
    (boot_strap == 2'b00 && !pd_d) |=> (sel_o == $past(sel_in))); // R9
endmodule

// File: tb/fdc_rate_ctl_tb.sv
`timescale 1ns/1ps
module fdc_rate_ctl_tb_top;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_rst_req = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] boot_strap = '0;
  logic [ND-1:0] sel_in = '0;
  logic [ND-1:0] mot_in = '0;
  logic [ND-1:0] sel_o, mot_o;
  logic [1:0] rate_o;
  logic [2:0] pcomp_o;
  logic srst_pulse_o, pd_o, clk_en_o, osc_en_o, out_valid_n_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fdc_rate_ctl #(.ADDR_W(3), .REG_ADDR(4), .NUM_DRV(ND)) dut_i (
    .clk(clk), .rst(rst), .hw_rst_req(hw_rst_req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .boot_strap(boot_strap), .sel_in(sel_in), .mot_in(mot_in),
    .sel_o(sel_o), .mot_o(mot_o), .rate_o(rate_o), .pcomp_o(pcomp_o),
    .srst_pulse_o(srst_pulse_o), .pd_o(pd_o), .clk_en_o(clk_en_o),
    .osc_en_o(osc_en_o), .out_valid_n_o(out_valid_n_o)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2:0] exp_map(logic [1:0] st, logic [2:0] v);
    case (st)
      2'b01:   return {v[2], v[0], v[1]};
      2'b10:   return {v[0], v[1], v[2]};
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rate", rate_o, 0);
    check("R1 pcomp", pcomp_o, 0);
    check("R1 pulse", srst_pulse_o, 0);
    check("R1 pd", pd_o, 0);
    check("R1 clk_en", clk_en_o, 1);
    check("R1 osc_en", osc_en_o, 1);
    check("R1 valid_n", out_valid_n_o, 0);
    check("R1 drives", {sel_o, mot_o}, 0);
    rst = 1'b0;

    for (int v = 0; v < 32; v++) begin
      reg_write(3'd4, 8'(v));
      check("R2 rate", rate_o, v & 3);
      check("R2 pcomp", pcomp_o, v >> 2);
    end

    reg_write(3'd4, 8'h0E);
    reg_write(3'd5, 8'hFF);
    check("R3 other addr rate", rate_o, 2);
    check("R3 other addr pcomp", pcomp_o, 3);
    check("R3 other addr pd", pd_o, 0);
    check("R3 other addr osc", osc_en_o, 1);
    check("R3 other addr pulse", srst_pulse_o, 0);
    @(negedge clk);
    addr = 3'd4; wdata = 8'hFF; wr_en = 1'b0;
    @(negedge clk);
    check("R3 no strobe rate", rate_o, 2);
    check("R3 no strobe pd", pd_o, 0);

    reg_write(3'd4, 8'h2B);
    check("R8 osc off", osc_en_o, 0);
    check("R8 clk stays", clk_en_o, 1);
    check("R8 no pd", pd_o, 0);
    check("R8 rate", rate_o, 3);
    reg_write(3'd4, 8'h0B);
    check("R8 osc back", osc_en_o, 1);

    reg_write(3'd4, 8'hFF);
    check("R4 pulse high", srst_pulse_o, 1);
    check("R4 rate cleared", rate_o, 0);
    check("R4 pcomp cleared", pcomp_o, 0);
    check("R4 no pd", pd_o, 0);
    check("R4 osc on", osc_en_o, 1);
    @(negedge clk);
    check("R4 pulse one cycle", srst_pulse_o, 0);

    boot_strap = 2'b00; sel_in = 3'b111; mot_in = 3'b101;
    @(negedge clk);
    check("R12 live drives", {sel_o, mot_o}, 6'b111101);
    reg_write(3'd4, 8'h49);
    check("R5 pd", pd_o, 1);
    check("R5 clk off", clk_en_o, 0);
    check("R5 osc off", osc_en_o, 0);
    check("R5 valid_n", out_valid_n_o, 1);
    check("R5 drives off", {sel_o, mot_o}, 0);
    check("R5 rate", rate_o, 1);
    reg_write(3'd4, 8'h06);
    check("R6 still pd", pd_o, 1);
    check("R6 rate updates", rate_o, 2);
    check("R6 pcomp updates", pcomp_o, 1);
    repeat (3) @(negedge clk);
    check("R6 drives still off", {sel_o, mot_o}, 0);
    reg_write(3'd4, 8'h80);
    check("R4 exit pd", pd_o, 0);
    check("R4 drives back", {sel_o, mot_o}, 6'b111101);
    check("R4 valid_n low", out_valid_n_o, 0);

    reg_write(3'd4, 8'h41);
    check("R5 pd again", pd_o, 1);
    @(negedge clk);
    hw_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_rst_req = 1'b0;
    check("R7 pd cleared", pd_o, 0);
    check("R7 rate cleared", rate_o, 0);
    check("R7 no pulse", srst_pulse_o, 0);
    check("R7 drives back", {sel_o, mot_o}, 6'b111101);

    for (int st = 0; st < 4; st++) begin
      for (int s = 0; s < 8; s++) begin
        for (int m = 0; m < 8; m++) begin
          string tag;
          case (st)
            1:       tag = "R10 select";
            2:       tag = "R11 select";
            default: tag = "R9 select";
          endcase
          @(negedge clk);
          boot_strap = 2'(st); sel_in = 3'(s); mot_in = 3'(m);
          @(negedge clk);
          check(tag, sel_o, exp_map(2'(st), 3'(s)));
          check("R12 motor", mot_o, exp_map(2'(st), 3'(m)));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule